// File: doc/BRIEF.md
# Load Dependency Prediction Bit Table

This block holds one prediction bit for every instruction word that can sit in the instruction cache. The bit says whether a load at that position was last seen to have a consumer among the three instructions right after it. A set bit (value 1) asks the data cache to read tags and all data ways in parallel, so the load result arrives early. A clear bit (value 0) allows tags first and then a single data way, which saves energy but takes one more cycle.

In the address-generation stage, decode flags a load. The instruction-cache set, the word-in-line index and the instruction-cache hit way, which is already known, select one bit. The registered prediction appears on the next cycle. The pipeline carries that predicted bit with the load, together with a bit that records whether the hazard logic stalled on that load. At commit both bits come back with the set, word and way captured at read time. The table is written with the observed bit only when the two bits disagree. No input invalidates entries. A stale bit only costs a stall, because the ordinary interlock still protects correctness.

Top module: `ldp_table`

## Requirements
- R1: The table has IC_SETS*LINE_WORDS rows of IC_WAYS bits. The row index is {set, word}, with the set in the upper bits. IC_SETS and LINE_WORDS are powers of two. Each (set, word, way) triple names its own bit.
- R2: After an asynchronous active-low reset, every entry holds 1 (parallel access), pred_valid_o is 0 and pred_par_o is 1.
- R3: pred_valid_o equals the previous cycle's ag_load_i. In a cycle with ag_load_i low, no read takes place, so pred_par_o keeps its value on the following cycle.
- R4: One cycle after ag_load_i is high, pred_par_o equals the entry at (ag_set_i, ag_word_i, ag_way_i). 1 means parallel tag/data access and 0 means sequential access.
- R5: When cm_valid_i is high and cm_pred_i differs from cm_stalled_i, the entry at (cm_set_i, cm_word_i, cm_way_i) takes the value of cm_stalled_i at that clock edge.
- R6: No entry changes when cm_valid_i is low, or when cm_pred_i equals cm_stalled_i, even if the stored bit differs from cm_pred_i.
- R7: When a read and a qualifying write name the same entry in the same cycle, the prediction returned is the newly written value.
- R8: A write changes only its own entry. The other ways of the same row, and all other rows, keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ag_load_i | input | 1 | Instruction in address generation is a load |
| ag_set_i | input | log2(IC_SETS) | Instruction-cache set of the load |
| ag_word_i | input | log2(LINE_WORDS) | Word index within the line |
| ag_way_i | input | log2(IC_WAYS) | Instruction-cache hit way |
| cm_valid_i | input | 1 | A load is committing |
| cm_set_i | input | log2(IC_SETS) | Set captured at read time |
| cm_word_i | input | log2(LINE_WORDS) | Word captured at read time |
| cm_way_i | input | log2(IC_WAYS) | Way captured at read time |
| cm_pred_i | input | 1 | Prediction bit that travelled with the load |
| cm_stalled_i | input | 1 | Observed-stall bit for the load |
| pred_valid_o | output | 1 | Prediction registered this cycle |
| pred_par_o | output | 1 | 1 = parallel access, 0 = sequential access |

## Verification
The bench builds the table with 2 ways, 4 sets and 4 words per line, for 16 rows and 32 bits in total. With this small table, random reads and commits collide on the same entry and on the same row very often. Same-cycle read/write forwarding, neighbour isolation and the agree-means-no-write rule therefore get exercised many times, not only in the directed cases. Every index boundary, including the top set, word and way, is reached within a few hundred cycles.

// File: rtl/ldp_pkg.sv
package ldp_pkg;

    typedef struct packed {
        logic vld;
        logic par;
    } pred_t;

    localparam pred_t PRED_RESET = '{vld: 1'b0, par: 1'b1};

endpackage

// File: rtl/ldp_rowmem.sv
module ldp_rowmem #(
    parameter int WAYS = 4,
    parameter int ROWS = 256,
    localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int WW  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RW-1:0]   rd_row,
    output logic [WAYS-1:0] rd_data,
    input  logic            wr_en,
    input  logic [RW-1:0]   wr_row,
    input  logic [WW-1:0]   wr_way,
    input  logic            wr_bit
);

    logic [ROWS-1:0][WAYS-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_row][wr_way] = wr_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '1;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_row];

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (mem_q == $past(mem_q)));                                   // R6

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(wr_row)][$past(wr_way)] == $past(wr_bit)));     // R5

endmodule

// File: rtl/ldp_waysel.sv
module ldp_waysel #(
    parameter int WAYS = 4,
    localparam int WW  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0] row,
    input  logic [WW-1:0]   way,
    output logic            bit_o
);

    logic [WAYS-1:0] hit;

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign hit[g] = (way == WW'(g)) & row[g];
    end

    assign bit_o = |hit;

endmodule

// File: rtl/ldp_train.sv
module ldp_train #(
    parameter int SW   = 5,
    parameter int OW   = 3,
    parameter int WW   = 2,
    localparam int RW  = SW + OW
) (
    input  logic          cm_valid,
    input  logic [SW-1:0] cm_set,
    input  logic [OW-1:0] cm_word,
    input  logic [WW-1:0] cm_way,
    input  logic          cm_pred,
    input  logic          cm_stalled,
    output logic          wr_en,
    output logic [RW-1:0] wr_row,
    output logic [WW-1:0] wr_way,
    output logic          wr_bit
);

    always_comb begin
        wr_en  = cm_valid && (cm_pred != cm_stalled);
        wr_row = {cm_set, cm_word};
        wr_way = cm_way;
        wr_bit = cm_stalled;
    end

endmodule

// File: rtl/ldp_table.sv
module ldp_table #(
    parameter int IC_WAYS    = 4,
    parameter int IC_SETS    = 32,
    parameter int LINE_WORDS = 8,
    localparam int SW   = (IC_SETS > 1) ? $clog2(IC_SETS) : 1,
    localparam int OW   = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1,
    localparam int WW   = (IC_WAYS > 1) ? $clog2(IC_WAYS) : 1,
    localparam int RW   = SW + OW,
    localparam int ROWS = 1 << RW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ag_load_i,
    input  logic [SW-1:0] ag_set_i,
    input  logic [OW-1:0] ag_word_i,
    input  logic [WW-1:0] ag_way_i,
    input  logic          cm_valid_i,
    input  logic [SW-1:0] cm_set_i,
    input  logic [OW-1:0] cm_word_i,
    input  logic [WW-1:0] cm_way_i,
    input  logic          cm_pred_i,
    input  logic          cm_stalled_i,
    output logic          pred_valid_o,
    output logic          pred_par_o
);
    import ldp_pkg::*;

    logic [RW-1:0]      rd_row;
    logic [IC_WAYS-1:0] rd_data;
    logic               sel_bit;
    logic               wr_en;
    logic [RW-1:0]      wr_row;
    logic [WW-1:0]      wr_way;
    logic               wr_bit;
    logic               fwd;
    pred_t              out_d, out_q;

    assign rd_row = {ag_set_i, ag_word_i};

    ldp_train #(.SW(SW), .OW(OW), .WW(WW)) u_train (
        .cm_valid   (cm_valid_i),
        .cm_set     (cm_set_i),
        .cm_word    (cm_word_i),
        .cm_way     (cm_way_i),
        .cm_pred    (cm_pred_i),
        .cm_stalled (cm_stalled_i),
        .wr_en      (wr_en),
        .wr_row     (wr_row),
        .wr_way     (wr_way),
        .wr_bit     (wr_bit)
    );

    ldp_rowmem #(.WAYS(IC_WAYS), .ROWS(ROWS)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_row  (rd_row),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_row  (wr_row),
        .wr_way  (wr_way),
        .wr_bit  (wr_bit)
    );

    ldp_waysel #(.WAYS(IC_WAYS)) u_sel (
        .row   (rd_data),
        .way   (ag_way_i),
        .bit_o (sel_bit)
    );

    assign fwd = wr_en && (wr_row == rd_row) && (wr_way == ag_way_i);

    always_comb begin
        out_d     = out_q;
        out_d.vld = ag_load_i;
        if (ag_load_i) begin
            out_d.par = fwd ? wr_bit : sel_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= PRED_RESET;
        end else begin
            out_q <= out_d;
        end
    end

    assign pred_valid_o = out_q.vld;
    assign pred_par_o   = out_q.par;

    AST_VALID_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        ag_load_i |=> pred_valid_o);                                            // R3

    AST_NO_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ag_load_i |=> (!pred_valid_o && $stable(pred_par_o)));                // R3

    AST_AGREE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cm_valid_i || (cm_pred_i == cm_stalled_i)) |-> !wr_en);              // R6

    AST_FORWARD_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (ag_load_i && cm_valid_i && (cm_pred_i != cm_stalled_i)
         && (cm_set_i == ag_set_i) && (cm_word_i == ag_word_i) && (cm_way_i == ag_way_i))
        |=> (pred_par_o == $past(cm_stalled_i)));                               // R7

endmodule

// File: tb/ldp_table_test.sv
`timescale 1ns/1ps
module ldp_table_test;
    localparam int WAYS = 2;
    localparam int SETS = 4;
    localparam int WORDS = 4;
    localparam int SW = 2;
    localparam int OW = 2;
    localparam int WW = 1;
    localparam int ROWS = SETS * WORDS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ag_load = 1'b0;
    logic [SW-1:0] ag_set = '0;
    logic [OW-1:0] ag_word = '0;
    logic [WW-1:0] ag_way = '0;
    logic cm_valid = 1'b0;
    logic [SW-1:0] cm_set = '0;
    logic [OW-1:0] cm_word = '0;
    logic [WW-1:0] cm_way = '0;
    logic cm_pred = 1'b0;
    logic cm_stalled = 1'b0;
    logic pred_valid, pred_par;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic ref_mem [ROWS][WAYS];
    logic e_vld = 1'b0;
    logic e_par = 1'b1;

    always #2.5 clk = ~clk;

    ldp_table #(.IC_WAYS(WAYS), .IC_SETS(SETS), .LINE_WORDS(WORDS)) uut (
        .clk(clk), .rst_n(rst_n),
        .ag_load_i(ag_load), .ag_set_i(ag_set), .ag_word_i(ag_word), .ag_way_i(ag_way),
        .cm_valid_i(cm_valid), .cm_set_i(cm_set), .cm_word_i(cm_word), .cm_way_i(cm_way),
        .cm_pred_i(cm_pred), .cm_stalled_i(cm_stalled),
        .pred_valid_o(pred_valid), .pred_par_o(pred_par)
    );

    function automatic int row_of(input logic [SW-1:0] s, input logic [OW-1:0] w);
        return int'(s) * WORDS + int'(w);
    endfunction

    task automatic check(input logic act, input logic exp, input string tag, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // called at a negedge: drive, predict, wait one cycle, compare
    task automatic cyc(input logic ld, input int s, input int w, input int y,
                       input logic cv, input int cs, input int cw, input int cy,
                       input logic cp, input logic cst, input string tag);
        logic wr;
        ag_load = ld; ag_set = SW'(s); ag_word = OW'(w); ag_way = WW'(y);
        cm_valid = cv; cm_set = SW'(cs); cm_word = OW'(cw); cm_way = WW'(cy);
        cm_pred = cp; cm_stalled = cst;
        wr = cv && (cp != cst);
        e_vld = ld;
        if (ld) begin
            if (wr && cs == s && cw == w && cy == y) e_par = cst;
            else e_par = ref_mem[row_of(SW'(s), OW'(w))][y];
        end
        if (wr) ref_mem[row_of(SW'(cs), OW'(cw))][cy] = cst;
        @(negedge clk);
        check(pred_valid, e_vld, tag, "pred_valid");
        check(pred_par, e_par, tag, "pred_par");
    endtask

    initial begin
        for (int r = 0; r < ROWS; r++)
            for (int y = 0; y < WAYS; y++) ref_mem[r][y] = 1'b1;
        repeat (3) @(negedge clk);
        // R2: reset outputs
        check(pred_valid, 1'b0, "R2", "reset pred_valid");
        check(pred_par, 1'b1, "R2", "reset pred_par");
        rst_n = 1'b1;
        @(negedge clk);
        // R2: entries start at parallel setting
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        cyc(1, 3, 3, 1, 0, 0, 0, 0, 0, 0, "R2");
        // R5: mismatch trains entry to 0
        cyc(0, 0, 0, 0, 1, 1, 2, 1, 1, 0, "R5");
        cyc(1, 1, 2, 1, 0, 0, 0, 0, 0, 0, "R5");
        // R8: neighbours untouched
        cyc(1, 1, 2, 0, 0, 0, 0, 0, 0, 0, "R8");
        cyc(1, 1, 3, 1, 0, 0, 0, 0, 0, 0, "R8");
        cyc(1, 0, 2, 1, 0, 0, 0, 0, 0, 0, "R8");
        // R6: agreeing bits do not write although stored bit differs
        cyc(0, 0, 0, 0, 1, 2, 0, 0, 0, 0, "R6");
        cyc(1, 2, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
        // R6: commit not valid does not write
        cyc(0, 0, 0, 0, 0, 2, 0, 0, 1, 0, "R6");
        cyc(1, 2, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
        // R7: same-cycle read and write of one entry
        cyc(1, 2, 1, 1, 1, 2, 1, 1, 1, 0, "R7");
        cyc(1, 2, 1, 1, 1, 2, 1, 1, 0, 1, "R7");
        cyc(1, 2, 1, 1, 0, 0, 0, 0, 0, 0, "R7");
        // R3: no load means no read, prediction held
        cyc(1, 1, 2, 1, 0, 0, 0, 0, 0, 0, "R3");
        cyc(0, 3, 3, 0, 1, 1, 2, 1, 0, 1, "R3");
        cyc(0, 1, 2, 1, 0, 0, 0, 0, 0, 0, "R3");
        cyc(1, 1, 2, 1, 0, 0, 0, 0, 0, 0, "R5");
        // R4/R1: random mix
        void'($urandom(32'd7113));
        for (int i = 0; i < 4000; i++) begin
            logic ld, cv, cp, cst;
            ld = ($urandom % 4) != 0;
            cv = ($urandom % 2) != 0;
            cp = $urandom % 2;
            cst = $urandom % 2;
            cyc(ld, $urandom % SETS, $urandom % WORDS, $urandom % WAYS,
                cv, $urandom % SETS, $urandom % WORDS, $urandom % WAYS, cp, cst, "R4");
        end
        // R1: sweep every entry against the model
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WORDS; w++)
                for (int y = 0; y < WAYS; y++)
                    cyc(1, s, w, y, 0, 0, 0, 0, 0, 0, "R1");
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule